// File: doc/BRIEF.md
# Register File with Odd-Word Address Remapping

This block is a byte-addressed on-chip register space with a small execution path for one instruction: a direct-mode load-word. The instruction comes in as a byte stream of three beats: an opcode, then a source register address, then a destination register address. The block reads a little-endian word from the source and writes it to the destination. This takes a fixed number of execution states. A separate byte port reads and writes single bytes at any time, and a plain output shows the stack-pointer word of the selected device variant.

The block's main job is to decode word addresses that are odd. It never faults such an access and never just rounds it down. In remap mode (`cfg_bank_mode`=0), an odd word address is cleared in bit 0 and offset by 0x100. In bank mode (`cfg_bank_mode`=1), bit 0 instead selects a second 256-byte bank at the aligned address. The rule applies to both operands. Byte accesses are never remapped.

Back-pressure on the instruction stream works as follows. A beat transfers only in a cycle where both `ins_valid` and `ins_ready` are high. `ins_ready` is high whenever no load is executing. It drops for the execution states after an accepted load, and the sender must hold its beat until ready returns.

Top module: `oddword_regfile`

## Requirements
- R1: Instruction beats transfer on `ins_valid && ins_ready`, in the order opcode, source address, destination address. The opcode 0xA0 is a load-word.
- R2: A load-word writes the destination with the source word. The word is little-endian: the low byte is at the aligned (even) index and the high byte at the next index.
- R3: After the destination beat of a load-word, `ins_ready` is low for exactly 4 cycles. `done` is high only in the 4th of these cycles. The new destination bytes are visible on the byte port from the following cycle.
- R4: With `cfg_bank_mode`=0, an even word address A uses bank 0 bytes A and A+1. An odd address A uses bank 0 bytes (A with bit 0 cleared)+0x100 and the byte after it. This holds for both operands.
- R5: With `cfg_bank_mode`=1, an even word address uses bank 0 as in R4. An odd address A uses bank 1 bytes (A with bit 0 cleared) and A. This holds for both operands. The mode is sampled at the destination beat.
- R6: The byte port reads combinationally and writes on the clock edge when `bp_we` is high. With `bp_bank`=0 it addresses bank 0 byte `bp_addr`. With `bp_bank`=1 it addresses bank 1 byte `bp_addr[7:0]`. Odd addresses touch only the addressed byte.
- R7: An opcode other than 0xA0 still consumes three beats. It writes nothing, raises no `done`, and `ins_ready` stays high.
- R8: `sp_word` shows the bank 0 word at 0x20 when `cfg_sp_alt`=0, and the word at 0x10 when `cfg_sp_alt`=1.
- R9: Synchronous reset returns the sequencer to waiting for an opcode (`ins_ready` high, `done` low) and drops a pending write. Register contents are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the sequencer, active high |
| cfg_bank_mode | input | 1 | 0: odd word offset by 0x100; 1: odd word selects bank 1 |
| cfg_sp_alt | input | 1 | Stack-pointer variant: 0 selects word 0x20, 1 selects word 0x10 |
| ins_valid | input | 1 | Instruction beat valid |
| ins_ready | output | 1 | Block accepts an instruction beat |
| ins_data | input | 8 | Instruction beat byte |
| done | output | 1 | Pulse in the cycle the destination write takes place |
| bp_bank | input | 1 | Byte port bank select |
| bp_addr | input | 9 | Byte port address |
| bp_we | input | 1 | Byte port write enable |
| bp_wdata | input | 8 | Byte port write data |
| bp_rdata | output | 8 | Byte port read data |
| sp_word | output | 16 | Stack-pointer word of the selected variant |

## Verification
The bench uses the default parameters: a 512-byte bank 0, a 256-byte bank 1, 8-bit operand addresses, offset 0x100 and 4 execution states. With these values every operand address, in both decode modes, lands somewhere the byte port can read back. The upper half of bank 0 is reachable only through remapped odd words, and all of bank 1 only through bank mode. Random loads over the full 8-bit operand range, mixed in both modes, meet odd sources and odd destinations alike. Directed cases pin down the 0x3B example, the reset during execution, and the rejected opcode.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    ST_OPC = 2'd0,
    ST_SRC = 2'd1,
    ST_DST = 2'd2,
    ST_EXE = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
  parameter int OPA_W     = 8,
  parameter int B0_AW     = 9,
  parameter int REMAP_OFS = 256,
  localparam int IDX_W    = B0_AW + 1
) (
  input  logic [OPA_W-1:0] addr,
  input  logic             bank_mode,
  output logic [IDX_W-1:0] idx
);
  logic [OPA_W-1:0] even;
  logic [B0_AW-1:0] shifted;

  always_comb begin
    even    = {addr[OPA_W-1:1], 1'b0};
    shifted = B0_AW'(even) + B0_AW'(REMAP_OFS);
    if (!addr[0])
      idx = IDX_W'(even);
    else if (bank_mode)
      idx = IDX_W'(2 ** B0_AW) + IDX_W'(even);
    else
      idx = IDX_W'(shifted);
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int OPA_W  = 8,
  parameter int B0_AW  = 9,
  localparam int IDX_W = B0_AW + 1,
  localparam int TOTAL = 2 ** B0_AW + 2 ** OPA_W
) (
  input  logic             clk,
  input  logic             ew_en,
  input  logic [IDX_W-1:0] ew_idx,
  input  logic [15:0]      ew_data,
  input  logic             bw_en,
  input  logic [IDX_W-1:0] bw_idx,
  input  logic [7:0]       bw_data,
  input  logic [IDX_W-1:0] rw_idx,
  output logic [15:0]      rw_data,
  input  logic [IDX_W-1:0] br_idx,
  output logic [7:0]       br_data,
  input  logic [IDX_W-1:0] sp_idx,
  output logic [15:0]      sp_data
);
  logic [7:0] mem [TOTAL];

  function automatic logic [IDX_W-1:0] hi_of(input logic [IDX_W-1:0] i);
    return {i[IDX_W-1:1], 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (bw_en) mem[bw_idx] <= bw_data;
    if (ew_en) begin
      mem[ew_idx]        <= ew_data[7:0];
      mem[hi_of(ew_idx)] <= ew_data[15:8];
    end
  end

  assign rw_data = {mem[hi_of(rw_idx)], mem[rw_idx]};
  assign br_data = mem[br_idx];
  assign sp_data = {mem[hi_of(sp_idx)], mem[sp_idx]};

  // R4 R5
  // word_align_chk
  word_align_chk: assert property (@(posedge clk) ew_en |-> !ew_idx[0]);
endmodule

// File: rtl/rf_seq.sv
module rf_seq
  import rf_pkg::*;
#(
  parameter int        IDX_W       = 10,
  parameter int        EXEC_STATES = 4,
  parameter logic [7:0] OPC_LDW    = 8'hA0,
  localparam int       CNT_W       = $clog2(EXEC_STATES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [7:0]       ins_data,
  output logic [7:0]       src_addr,
  input  logic [15:0]      src_word,
  input  logic [IDX_W-1:0] dst_idx,
  output logic             ew_en,
  output logic [IDX_W-1:0] ew_idx,
  output logic [15:0]      ew_data,
  output logic             done
);
  seq_state_t       state;
  logic             opc_ok;
  logic [CNT_W-1:0] cnt;
  logic             take;

  assign ins_ready = (state != ST_EXE);
  assign take      = ins_valid && ins_ready;
  assign done      = (state == ST_EXE) && (cnt == CNT_W'(EXEC_STATES - 1));
  assign ew_en     = done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_OPC;
      opc_ok <= 1'b0;
      cnt    <= '0;
    end else begin
      case (state)
        ST_OPC: if (take) begin
          opc_ok <= (ins_data == OPC_LDW);
          state  <= ST_SRC;
        end
        ST_SRC: if (take) state <= ST_DST;
        ST_DST: if (take) begin
          cnt   <= '0;
          state <= opc_ok ? ST_EXE : ST_OPC;
        end
        default: begin
          if (done) state <= ST_OPC;
          else      cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_SRC && take) src_addr <= ins_data;
    if (state == ST_DST && take && opc_ok) begin
      ew_data <= src_word;
      ew_idx  <= dst_idx;
    end
  end

  // R3
  // done_single_chk
  done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R3
  // exec_stall_chk
  exec_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DST && take && opc_ok) |=> (!ins_ready && !done));

  // R7
  // bad_opc_chk
  bad_opc_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DST && take && !opc_ok) |=> (ins_ready && !done));

  // R9
  // reset_idle_chk
  reset_idle_chk: assert property (@(posedge clk) rst |=> (ins_ready && !done));
endmodule

// File: rtl/oddword_regfile.sv
module oddword_regfile #(
  parameter int         OPA_W       = 8,
  parameter int         B0_AW       = 9,
  parameter int         REMAP_OFS   = 256,
  parameter int         EXEC_STATES = 4,
  parameter logic [7:0] OPC_LDW     = 8'hA0,
  parameter int         SP_BASE     = 'h20,
  parameter int         SP_ALT      = 'h10,
  localparam int        IDX_W       = B0_AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_bank_mode,
  input  logic             cfg_sp_alt,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [7:0]       ins_data,
  output logic             done,
  input  logic             bp_bank,
  input  logic [B0_AW-1:0] bp_addr,
  input  logic             bp_we,
  input  logic [7:0]       bp_wdata,
  output logic [7:0]       bp_rdata,
  output logic [15:0]      sp_word
);
  logic [7:0]       src_addr;
  logic [IDX_W-1:0] src_idx, dst_idx, ew_idx, bp_idx, sp_idx;
  logic [15:0]      src_word, ew_data;
  logic             ew_en;

  rf_addr_map #(.OPA_W(OPA_W), .B0_AW(B0_AW), .REMAP_OFS(REMAP_OFS)) u_map_src (
    .addr(src_addr), .bank_mode(cfg_bank_mode), .idx(src_idx));

  rf_addr_map #(.OPA_W(OPA_W), .B0_AW(B0_AW), .REMAP_OFS(REMAP_OFS)) u_map_dst (
    .addr(ins_data), .bank_mode(cfg_bank_mode), .idx(dst_idx));

  assign bp_idx = bp_bank ? (IDX_W'(2 ** B0_AW) + IDX_W'(bp_addr[OPA_W-1:0]))
                          : IDX_W'(bp_addr);
  assign sp_idx = cfg_sp_alt ? IDX_W'(SP_ALT) : IDX_W'(SP_BASE);

  rf_seq #(.IDX_W(IDX_W), .EXEC_STATES(EXEC_STATES), .OPC_LDW(OPC_LDW)) u_seq (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .src_addr(src_addr), .src_word(src_word),
    .dst_idx(dst_idx), .ew_en(ew_en), .ew_idx(ew_idx), .ew_data(ew_data),
    .done(done));

  rf_storage #(.OPA_W(OPA_W), .B0_AW(B0_AW)) u_store (
    .clk(clk), .ew_en(ew_en), .ew_idx(ew_idx), .ew_data(ew_data),
    .bw_en(bp_we), .bw_idx(bp_idx), .bw_data(bp_wdata),
    .rw_idx(src_idx), .rw_data(src_word),
    .br_idx(bp_idx), .br_data(bp_rdata),
    .sp_idx(sp_idx), .sp_data(sp_word));
endmodule

// File: tb/tb_oddword_regfile.sv
module tb_oddword_regfile;
  localparam int CLK_P = 10;
  localparam int NB    = 768;

  logic clk = 0, rst = 1;
  logic cfg_bank_mode = 0, cfg_sp_alt = 0;
  logic ins_valid = 0, ins_ready;
  logic [7:0] ins_data = 0;
  logic done;
  logic bp_bank = 0, bp_we = 0;
  logic [8:0] bp_addr = 0;
  logic [7:0] bp_wdata = 0, bp_rdata;
  logic [15:0] sp_word;

  int n_tot = 0, n_bad = 0;
  logic [7:0] model [NB];

  always #(CLK_P/2) clk = ~clk;

  oddword_regfile dut (
    .clk(clk), .rst(rst), .cfg_bank_mode(cfg_bank_mode), .cfg_sp_alt(cfg_sp_alt),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data), .done(done),
    .bp_bank(bp_bank), .bp_addr(bp_addr), .bp_we(bp_we), .bp_wdata(bp_wdata),
    .bp_rdata(bp_rdata), .sp_word(sp_word));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int map_idx(input logic [7:0] a, input bit bm);
    int e = a & 8'hFE;
    if (!a[0]) return e;
    if (bm) return 512 + e;
    return (e + 256) % 512;
  endfunction

  function automatic logic [15:0] mword(input int i);
    return {model[i | 1], model[i]};
  endfunction

  task automatic bp_wr(input int i, input logic [7:0] d);
    @(negedge clk);
    bp_bank = (i >= 512); bp_addr = 9'((i >= 512) ? i - 512 : i);
    bp_wdata = d; bp_we = 1;
    @(negedge clk);
    bp_we = 0;
    model[i] = d;
  endtask

  task automatic bp_rd(input int i, output logic [7:0] d);
    bp_bank = (i >= 512); bp_addr = 9'((i >= 512) ? i - 512 : i);
    #1 d = bp_rdata;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    ins_valid = 1; ins_data = b;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic check_word(input int i, input string tag);
    logic [7:0] lo, hi;
    bp_rd(i, lo); bp_rd(i | 1, hi);
    chk({hi, lo} == mword(i), tag, {hi, lo}, mword(i));
  endtask

  task automatic ldw(input logic [7:0] opc, input logic [7:0] s, input logic [7:0] d,
                     input bit bm, input string tag);
    bit tim_ok = 1;
    int si = map_idx(s, bm), di = map_idx(d, bm);
    logic [15:0] w = mword(si);
    cfg_bank_mode = bm;
    send(opc); send(s); send(d);
    if (opc == 8'hA0) begin
      for (int k = 1; k <= 4; k++) begin
        if (ins_ready !== 1'b0 || done !== (k == 4)) tim_ok = 0;
        if (k < 4) @(negedge clk);
      end
      @(negedge clk);
      if (ins_ready !== 1'b1 || done !== 1'b0) tim_ok = 0;
      chk(tim_ok, "R3 ready/done timing", {31'd0, tim_ok}, 1);
      model[di] = w[7:0]; model[di | 1] = w[15:8];
    end else begin
      chk(ins_ready === 1'b1 && done === 1'b0, "R7 bad opcode keeps ready/no done",
          {ins_ready, done}, 2'b10);
    end
    check_word(di, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int errs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ins_ready === 1'b1 && done === 1'b0, "R9 reset state", {ins_ready, done}, 2'b10);
    rst = 0;
    for (int i = 0; i < NB; i++) bp_wr(i, 8'($urandom));

    // R6 odd byte access touches one byte only
    bp_wr('h3A, 8'h3A); bp_wr('h3B, 8'h3B); bp_wr('h13A, 8'h11); bp_wr('h13B, 8'h22);
    bp_wr(512 + 'h3A, 8'h55); bp_wr(512 + 'h3B, 8'h66);
    bp_wr('h3B, 8'h3B);
    bp_rd('h3A, b); chk(b == 8'h3A, "R6 neighbour byte untouched", b, 8'h3A);
    bp_rd('h13B, b); chk(b == 8'h22, "R6 no remap on byte write", b, 8'h22);

    // R2 R4 even source, little-endian
    ldw(8'hA0, 8'h3A, 8'h30, 0, "R2 even source word 0x3B3A");
    bp_rd('h30, b); chk(b == 8'h3A, "R2 low byte at even index", b, 8'h3A);
    // R4 odd source remap
    ldw(8'hA0, 8'h3B, 8'h32, 0, "R4 odd source remapped to 0x13A");
    bp_rd('h33, b); chk(b == 8'h22, "R4 high byte from 0x13B", b, 8'h22);
    // R4 odd destination remap
    ldw(8'hA0, 8'h3A, 8'h41, 0, "R4 odd destination remapped to 0x140");
    // R5 bank mode odd source and destination
    ldw(8'hA0, 8'h3B, 8'h50, 1, "R5 odd source from bank 1");
    bp_rd('h51, b); chk(b == 8'h66, "R5 bank 1 high byte", b, 8'h66);
    ldw(8'hA0, 8'h3A, 8'h61, 1, "R5 odd destination into bank 1");
    // R7 other opcode
    ldw(8'hA1, 8'h3A, 8'h70, 0, "R7 other opcode writes nothing");
    ldw(8'h00, 8'h3B, 8'h71, 1, "R7 other opcode odd dst writes nothing");

    // R8 stack pointer variant
    bp_wr('h20, 8'hCD); bp_wr('h21, 8'hAB); bp_wr('h10, 8'h34); bp_wr('h11, 8'h12);
    cfg_sp_alt = 0; #1 chk(sp_word == 16'hABCD, "R8 sp at 0x20", sp_word, 16'hABCD);
    cfg_sp_alt = 1; #1 chk(sp_word == 16'h1234, "R8 sp at 0x10", sp_word, 16'h1234);

    // R9 reset during execution drops the write, keeps contents
    cfg_bank_mode = 0;
    send(8'hA0); send(8'h3A); send(8'h80);
    rst = 1; @(negedge clk); rst = 0;
    chk(ins_ready === 1'b1 && done === 1'b0, "R9 reset aborts exec", {ins_ready, done}, 2'b10);
    check_word('h80, "R9 pending write dropped");
    check_word('h3A, "R9 contents kept");

    // R1 R4 R5 random loads
    for (int n = 0; n < 60; n++)
      ldw(8'hA0, 8'($urandom), 8'($urandom), bit'($urandom % 2), "R1 random load");

    // R6 full readback
    errs = 0;
    for (int i = 0; i < NB; i++) begin
      bp_rd(i, b);
      if (b != model[i]) errs++;
    end
    chk(errs == 0, "R6 full byte readback mismatches", errs, 0);

    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule